// File: doc/BRIEF.md
# Pipelined burst SRAM

A synchronous single-port static memory with a registered address path, a registered read-data path and one shared data bus. The bus is modelled as separate in and out vectors plus an output-drive flag. An access opens on a rising clock edge when either of two address strobes is low and all three chip selects are active. The first strobe comes from the processor side and the second from the controller side, and the two differ in when they take write data. After an access has opened, later cycles without a strobe either repeat the current word or, when the advance input is low, step to the next address of a four-beat wrapping burst. The burst can run in linear or interleaved order.

Writes cover the whole 36-bit word or any subset of four 9-bit lanes. The output drive is withheld on the first cycle after the block leaves the deselected state, during write cycles, and right after a deselect. A two-flop sleep handshake puts the block to sleep while keeping the stored contents. The depth is a parameter (default 256 words).

Top module: `pipelined_burst_sram`

## Requirements
- R1: An access starts at a rising edge when a strobe is low and the selects are active: `sel_a_ni` low, `sel_b_i` high and `sel_c_ni` low. A strobe at an edge where any select is inactive starts nothing.
- R2: The processor strobe `proc_strobe_ni` has no effect while `sel_a_ni` is high. A running burst then continues as if no strobe were present, and only the controller strobe can start or deselect.
- R3: A read takes its address at edge k, and the word appears on `dq_o` with `dq_oe_o` high (given `out_en_ni` low) after edge k+1. Back-to-back reads give one word per cycle.
- R4: In the cycle after an access starts from the idle or deselected state, `dq_oe_o` is low.
- R5: At a processor-strobe start, the write controls and `burst_adv_ni` are ignored and the edge counts as a read. At the next edge without a strobe, the write controls and `dq_i` are sampled and a write takes place.
- R6: A controller-strobe start (processor strobe high or ignored) samples the write controls and `dq_i` on the same edge and writes in that one cycle.
- R7: Lane enables: `wr_all_ni` low enables all four lanes. Otherwise, `lane_wr_ni` low enables lane n when `lane_sel_ni[n]` is low, where lane n is bits 9n+8..9n. Otherwise there is no write and the cycle is a read. Unselected lanes keep their contents.
- R8: A write at edge k holds `dq_oe_o` low in the following cycle. `out_en_ni` high holds `dq_oe_o` low at once, without waiting for a clock edge.
- R9: A strobe with the selects inactive deselects the block. `dq_oe_o` is low in the next cycle, even if a read was pending, and the burst ends.
- R10: While an access is open, a cycle without a strobe uses the next burst address if `burst_adv_ni` is low, or the same address if it is high. The low two address bits are the start bits plus the count, modulo 4, when `interleave_i` is 0, and the start bits XOR the count when it is 1. The mode is taken at the start, and the upper address bits never change within a burst.
- R11: `sleep_o` goes high two edges after `sleep_req_i` is sampled high and low two edges after it is sampled low. While `sleep_o` is high, no access starts or continues and any open access is dropped. The stored words are kept.
- R12: During and after reset, `dq_oe_o` and `sleep_o` are low and no access is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Word address taken at a start |
| interleave_i | input | 1 | Burst order at a start: 0 linear, 1 interleaved |
| proc_strobe_ni | input | 1 | Processor-side address strobe, active low |
| ctrl_strobe_ni | input | 1 | Controller-side address strobe, active low |
| burst_adv_ni | input | 1 | Step to the next burst address, active low |
| sel_a_ni | input | 1 | Chip select A, active low; also gates the processor strobe |
| sel_b_i | input | 1 | Chip select B, active high |
| sel_c_ni | input | 1 | Chip select C, active low |
| wr_all_ni | input | 1 | Write all lanes, active low |
| lane_wr_ni | input | 1 | Lane-write enable, active low |
| lane_sel_ni | input | 4 | Per-lane write select, active low |
| out_en_ni | input | 1 | Output enable, active low, combinational |
| sleep_req_i | input | 1 | Sleep request |
| dq_i | input | 36 | Write data from the shared bus |
| dq_o | output | 36 | Read data onto the shared bus |
| dq_oe_o | output | 1 | Bus drive enable |
| sleep_o | output | 1 | Block is asleep |

## Verification
Each state register shows up at the pins within one or two cycles. A wrong burst counter or wrong order mode makes the next read in a burst return a different preloaded word. A lost open-access flag turns a continuation into a silent idle cycle, and `dq_oe_o` stays low where a word was due. A drive flag that fails to clear after a write, a deselect or a fresh start shows up as `dq_oe_o` high in that very cycle. A write lane decode or processor-strobe write that lands on the wrong edge shows only when the word is read back, two cycles after the read-back starts. That is why every address is preloaded with a distinct pattern and random traffic revisits a small address window.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DATA_W = LANES * LANE_W;

  typedef enum logic {
    BURST_LINEAR      = 1'b0,
    BURST_INTERLEAVED = 1'b1
  } burst_mode_e;
endpackage

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic          mode_i,
  input  logic          step_i,
  output logic [AW-1:0] cur_addr_o,
  output logic [AW-1:0] nxt_addr_o
);
  import sram_pkg::*;

  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  burst_mode_e   mode_q;

  function automatic logic [1:0] low_bits(logic [1:0] b, logic [1:0] c, burst_mode_e m);
    return (m == BURST_INTERLEAVED) ? (b ^ c) : (b + c);
  endfunction

  assign cur_addr_o = {base_q[AW-1:2], low_bits(base_q[1:0], cnt_q, mode_q)};
  assign nxt_addr_o = {base_q[AW-1:2], low_bits(base_q[1:0], cnt_q + 2'd1, mode_q)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
      mode_q <= BURST_LINEAR;
    end else if (load_i) begin
      base_q <= addr_i;
      cnt_q  <= '0;
      mode_q <= burst_mode_e'(mode_i);
    end else if (step_i) begin
      cnt_q <= cnt_q + 2'd1;
    end
  end

  // R10
  upper_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (cur_addr_o[AW-1:2] == $past(cur_addr_o[AW-1:2])));
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int DEPTH  = 256,
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [LANES-1:0] be_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             re_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [DW-1:0]    rdata_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];
    logic [LANE_W-1:0] rd_q;

    // read returns the pre-write word when both hit one edge
    always_ff @(posedge clk_i) begin
      if (we_i && be_i[g]) mem_q[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
      if (re_i) rd_q <= mem_q[raddr_i];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/sleep_sync.sv
module sleep_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic sleep_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[0], req_i};
  end

  assign sleep_o = sync_q[1];

  // R11
  sleep_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sleep_o) |-> $past(req_i, 2));
  // R11
  sleep_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sleep_o) |-> !$past(req_i, 2));
endmodule

// File: rtl/pipelined_burst_sram.sv
module pipelined_burst_sram #(
  parameter int  DEPTH = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [AW-1:0]               addr_i,
  input  logic                        interleave_i,
  input  logic                        proc_strobe_ni,
  input  logic                        ctrl_strobe_ni,
  input  logic                        burst_adv_ni,
  input  logic                        sel_a_ni,
  input  logic                        sel_b_i,
  input  logic                        sel_c_ni,
  input  logic                        wr_all_ni,
  input  logic                        lane_wr_ni,
  input  logic [sram_pkg::LANES-1:0]  lane_sel_ni,
  input  logic                        out_en_ni,
  input  logic                        sleep_req_i,
  input  logic [sram_pkg::DATA_W-1:0] dq_i,
  output logic [sram_pkg::DATA_W-1:0] dq_o,
  output logic                        dq_oe_o,
  output logic                        sleep_o
);
  import sram_pkg::*;

  logic             selected, proc_eff, strobe, awake;
  logic             start, desel, cont, step, wr_en, rd_en;
  logic [LANES-1:0] lane_en;
  logic [AW-1:0]    cur_addr, nxt_addr, acc_addr, rd_addr_q;
  logic             active_q, rd_pend_q, drv_q;

  assign selected = !sel_a_ni && sel_b_i && !sel_c_ni;
  assign proc_eff = !proc_strobe_ni && !sel_a_ni;
  assign strobe   = proc_eff || !ctrl_strobe_ni;
  assign awake    = !sleep_o;

  always_comb begin
    if (!wr_all_ni)      lane_en = '1;
    else if (!lane_wr_ni) lane_en = ~lane_sel_ni;
    else                  lane_en = '0;
  end

  assign start = awake && strobe && selected;
  assign desel = awake && strobe && !selected;
  assign cont  = awake && !strobe && active_q;
  assign step  = cont && !burst_adv_ni;

  // processor-strobe start never writes; its data comes on the next edge
  assign wr_en = ((start && !proc_eff) || cont) && (|lane_en);
  assign rd_en = (start && proc_eff) || (((start && !proc_eff) || cont) && !(|lane_en));

  always_comb begin
    if (start)     acc_addr = addr_i;
    else if (step) acc_addr = nxt_addr;
    else           acc_addr = cur_addr;
  end

  burst_seq #(.AW(AW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start),
    .addr_i     (addr_i),
    .mode_i     (interleave_i),
    .step_i     (step),
    .cur_addr_o (cur_addr),
    .nxt_addr_o (nxt_addr)
  );

  sram_array #(
    .DEPTH  (DEPTH),
    .AW     (AW),
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_array (
    .clk_i   (clk_i),
    .we_i    (wr_en),
    .be_i    (lane_en),
    .waddr_i (acc_addr),
    .wdata_i (dq_i),
    .re_i    (rd_pend_q),
    .raddr_i (rd_addr_q),
    .rdata_o (dq_o)
  );

  sleep_sync u_sleep (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (sleep_req_i),
    .sleep_o (sleep_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      rd_pend_q <= 1'b0;
      rd_addr_q <= '0;
      drv_q     <= 1'b0;
    end else begin
      if (!awake)     active_q <= 1'b0;
      else if (start) active_q <= 1'b1;
      else if (desel) active_q <= 1'b0;
      rd_pend_q <= rd_en;
      if (rd_en) rd_addr_q <= acc_addr;
      drv_q <= rd_pend_q && !wr_en && !desel && awake;
    end
  end

  assign dq_oe_o = drv_q && !out_en_ni;

  // R8
  wr_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> !dq_oe_o);
  // R9
  desel_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desel |=> !dq_oe_o);
  // R4
  first_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !active_q) |=> !dq_oe_o);
  // R11
  asleep_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o |=> !dq_oe_o);
endmodule

// File: tb/pipelined_burst_sram_tb.sv
`timescale 1ns/1ps
module pipelined_burst_sram_tb;
  localparam int AW = 8;
  localparam int DEPTH = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr;
  logic mode, proc_n, ctrl_n, adv_n, sel_a_n, sel_b, sel_c_n;
  logic wr_all_n, lane_wr_n, oe_n, zz;
  logic [3:0] lane_sel_n;
  logic [35:0] dq_in;
  logic [35:0] dq_out;
  logic dq_oe, slp;

  int n_chk = 0;
  int n_fail = 0;

  // bench model
  logic [35:0] m_mem [DEPTH];
  logic m_active = 0, m_rdp = 0, m_drv = 0, m_z1 = 0, m_z2 = 0, m_mode = 0;
  logic [AW-1:0] m_base = '0, m_rdaddr = '0;
  logic [1:0] m_cnt = '0;
  logic [35:0] m_dout = '0;

  always #2.5 clk = ~clk;

  pipelined_burst_sram #(.DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .interleave_i(mode),
    .proc_strobe_ni(proc_n), .ctrl_strobe_ni(ctrl_n), .burst_adv_ni(adv_n),
    .sel_a_ni(sel_a_n), .sel_b_i(sel_b), .sel_c_ni(sel_c_n),
    .wr_all_ni(wr_all_n), .lane_wr_ni(lane_wr_n), .lane_sel_ni(lane_sel_n),
    .out_en_ni(oe_n), .sleep_req_i(zz), .dq_i(dq_in),
    .dq_o(dq_out), .dq_oe_o(dq_oe), .sleep_o(slp)
  );

  function automatic logic [AW-1:0] seq_addr(logic [AW-1:0] b, logic [1:0] c, logic m);
    logic [1:0] lo;
    lo = m ? (b[1:0] ^ c) : (b[1:0] + c);
    return {b[AW-1:2], lo};
  endfunction

  function automatic logic [35:0] pattern(int i);
    return {4'ha, i[7:0], 8'h5c, ~i[7:0], i[7:0]};
  endfunction

  task automatic chk(string tag, string what, logic [35:0] act, logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic set_idle();
    addr = '0; mode = 0; proc_n = 1; ctrl_n = 1; adv_n = 1;
    sel_a_n = 0; sel_b = 1; sel_c_n = 0;
    wr_all_n = 1; lane_wr_n = 1; lane_sel_n = 4'hf; oe_n = 0; zz = 0;
    dq_in = '0;
  endtask

  task automatic model_edge();
    logic sel, pe, strobe, start, desel, cont, step, wr, rd, asleep;
    logic [3:0] be;
    logic [AW-1:0] a;
    asleep = m_z2;
    sel    = !sel_a_n && sel_b && !sel_c_n;
    pe     = !proc_n && !sel_a_n;
    strobe = pe || !ctrl_n;
    be     = !wr_all_n ? 4'hf : (!lane_wr_n ? ~lane_sel_n : 4'h0);
    start  = !asleep && strobe && sel;
    desel  = !asleep && strobe && !sel;
    cont   = !asleep && !strobe && m_active;
    step   = cont && !adv_n;
    wr     = ((start && !pe) || cont) && (be != 4'h0);
    rd     = (start && pe) || (((start && !pe) || cont) && be == 4'h0);
    if (start)     a = addr;
    else if (step) a = seq_addr(m_base, m_cnt + 2'd1, m_mode);
    else           a = seq_addr(m_base, m_cnt, m_mode);
    if (m_rdp) m_dout = m_mem[m_rdaddr];
    m_drv = m_rdp && !wr && !desel && !asleep;
    if (wr) for (int l = 0; l < 4; l++) if (be[l]) m_mem[a][l*9 +: 9] = dq_in[l*9 +: 9];
    m_rdp = rd;
    if (rd) m_rdaddr = a;
    if (asleep)     m_active = 0;
    else if (start) m_active = 1;
    else if (desel) m_active = 0;
    if (start) begin m_base = addr; m_cnt = 2'd0; m_mode = mode; end
    else if (step) m_cnt = m_cnt + 2'd1;
    m_z2 = m_z1;
    m_z1 = zz;
  endtask

  task automatic cyc(string tag);
    logic eo;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    eo = m_drv && !oe_n;
    chk(tag, "sleep_o", {35'd0, slp}, {35'd0, m_z2});
    chk(tag, "dq_oe_o", {35'd0, dq_oe}, {35'd0, eo});
    if (eo) chk(tag, "dq_o", dq_out, m_dout);
  endtask

  task automatic adsc_wr(int a, logic [35:0] d, string tag);
    set_idle(); ctrl_n = 0; addr = a[AW-1:0]; wr_all_n = 0; dq_in = d; cyc(tag);
  endtask
  task automatic adsc_rd(int a, string tag);
    set_idle(); ctrl_n = 0; addr = a[AW-1:0]; cyc(tag);
  endtask
  task automatic deselect(string tag);
    set_idle(); ctrl_n = 0; sel_b = 0; cyc(tag);
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    set_idle();
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", "dq_oe_o", {35'd0, dq_oe}, 36'd0);
    chk("R12", "sleep_o", {35'd0, slp}, 36'd0);
    rst_n = 1;
    cyc("R12");

    // R6 single-cycle writes preload every word
    for (int i = 0; i < DEPTH; i++) adsc_wr(i, pattern(i), "R6");
    deselect("R9");

    // R3 back-to-back reads, R4 first cycle blank
    adsc_rd(5, "R4");
    adsc_rd(6, "R3");
    adsc_rd(7, "R3");
    set_idle(); cyc("R3");
    set_idle(); cyc("R3");
    deselect("R9");
    cyc("R9");

    // R5 processor-strobe write: controls ignored first edge
    set_idle(); proc_n = 0; addr = 8'd20; wr_all_n = 0; adv_n = 0; dq_in = 36'hbad_bad_bad; cyc("R5");
    set_idle(); wr_all_n = 0; dq_in = 36'h1_2345_6789; cyc("R5");
    adsc_rd(20, "R5"); adsc_rd(21, "R5"); adsc_rd(20, "R5");
    set_idle(); cyc("R5");
    deselect("R5");

    // R7 lane writes
    set_idle(); ctrl_n = 0; addr = 8'd30; lane_wr_n = 0; lane_sel_n = 4'b1010; dq_in = 36'hf_ffff_ffff; cyc("R7");
    set_idle(); ctrl_n = 0; addr = 8'd31; lane_sel_n = 4'b0000; dq_in = 36'h0; cyc("R7");
    set_idle(); ctrl_n = 0; addr = 8'd32; wr_all_n = 0; lane_wr_n = 1; lane_sel_n = 4'b1111; dq_in = 36'h9_8765_4321; cyc("R7");
    adsc_rd(30, "R7"); adsc_rd(31, "R7"); adsc_rd(32, "R7");
    set_idle(); cyc("R7");
    deselect("R7");

    // R8 write and output-enable blanking
    adsc_rd(40, "R8");
    set_idle(); oe_n = 1; cyc("R8");
    set_idle(); wr_all_n = 0; dq_in = 36'h0_0000_0abc; cyc("R8");
    set_idle(); cyc("R8");
    set_idle(); cyc("R8");
    deselect("R8");

    // R1 inactive selects start nothing
    set_idle(); ctrl_n = 0; sel_c_n = 1; addr = 8'd50; wr_all_n = 0; dq_in = '1; cyc("R1");
    set_idle(); proc_n = 0; sel_b = 0; addr = 8'd50; cyc("R1");
    set_idle(); cyc("R1");
    adsc_rd(50, "R1"); set_idle(); cyc("R1"); deselect("R1");

    // R2 processor strobe ignored while select A high
    adsc_rd(60, "R2");
    set_idle(); proc_n = 0; sel_a_n = 1; adv_n = 0; cyc("R2");
    set_idle(); cyc("R2");
    set_idle(); proc_n = 0; sel_a_n = 1; addr = 8'd70; cyc("R2");
    set_idle(); cyc("R2");
    deselect("R2");

    // R10 bursts in both orders, read and write
    set_idle(); ctrl_n = 0; addr = 8'h41; mode = 0; cyc("R10");
    for (int k = 0; k < 5; k++) begin set_idle(); adv_n = 0; mode = 1; cyc("R10"); end
    set_idle(); proc_n = 0; addr = 8'h42; mode = 1; cyc("R10");
    for (int k = 0; k < 5; k++) begin set_idle(); adv_n = 0; cyc("R10"); end
    set_idle(); ctrl_n = 0; addr = 8'h4b; mode = 1; wr_all_n = 0; dq_in = 36'h0_1111_0001; cyc("R10");
    for (int k = 0; k < 3; k++) begin set_idle(); adv_n = 0; wr_all_n = 0; dq_in = 36'h0_2222_0000 + k; cyc("R10"); end
    adsc_rd(8'h48, "R10");
    for (int k = 0; k < 4; k++) begin set_idle(); adv_n = 0; cyc("R10"); end
    deselect("R10");

    // R11 sleep handshake, accesses ignored, contents kept
    adsc_rd(90, "R11");
    set_idle(); zz = 1; cyc("R11");
    set_idle(); zz = 1; cyc("R11");
    for (int k = 0; k < 4; k++) adsc_wr(90 + k, 36'h0, "R11");
    for (int k = 0; k < 4; k++) begin set_idle(); zz = (k < 2); cyc("R11"); end
    for (int k = 0; k < 4; k++) adsc_rd(90 + k, "R11");
    set_idle(); cyc("R11");
    deselect("R11");

    // constrained random traffic over a small window
    set_idle();
    for (int n = 0; n < 4000; n++) begin
      addr       = AW'($urandom_range(0, 31));
      mode       = 1'($urandom_range(0, 1));
      sel_a_n    = ($urandom_range(0, 99) < 10);
      sel_b      = ($urandom_range(0, 99) >= 8);
      sel_c_n    = ($urandom_range(0, 99) < 8);
      proc_n     = ($urandom_range(0, 99) >= 20);
      ctrl_n     = ($urandom_range(0, 99) >= 25);
      adv_n      = 1'($urandom_range(0, 1));
      wr_all_n   = ($urandom_range(0, 99) >= 15);
      lane_wr_n  = ($urandom_range(0, 99) >= 25);
      lane_sel_n = 4'($urandom_range(0, 15));
      oe_n       = ($urandom_range(0, 99) < 15);
      if ($urandom_range(0, 99) < 2) zz = !zz;
      dq_in      = {4'($urandom_range(0, 15)), 32'($urandom)};
      cyc("R3");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule